// File: doc/BRIEF.md
# Windowed Sub-Register File

This block is a bank of general-purpose 64-bit registers in which every register is reached through narrower views as well as in full. The narrower views are the low 32 bits, the low 16 bits, the low byte, and the byte just above the low byte. A single write port takes a register number, a view code and data. It turns that into a full-width register update. Depending on the view, the update either clears everything above the written field or keeps the bits around it unchanged.

A single combinational read port takes a register number and a view code. It returns the selected view right-aligned and padded with zeros to the full width. When the read and a write address the same register in the same cycle, the read returns the value the write is about to store. A datapath can therefore consume a result in the cycle it is produced.

Top module: `regwin_file`

## Requirements
- R1: After reset every register holds zero, and a full-width read of any register returns 0.
- R2: View codes are 0 = bits 7:0, 1 = bits 15:8, 2 = bits 15:0, 3 = bits 31:0, 4 = bits 63:0. A read returns the selected bits in bits 0 upward, and every output bit above the view is 0.
- R3: A code-3 write loads bits 31:0 from wr_data[31:0] and forces bits 63:32 of the register to zero.
- R4: A code-0 write loads bits 7:0 from wr_data[7:0] and leaves bits 63:8 unchanged.
- R5: A code-1 write loads bits 15:8 from wr_data[7:0] and leaves bits 63:16 and 7:0 unchanged.
- R6: A code-2 write loads bits 15:0 from wr_data[15:0] and leaves bits 63:16 unchanged.
- R7: A code-4 write replaces the whole register with wr_data.
- R8: A write with code 5, 6 or 7 changes no register, and a read with such a code returns 0.
- R9: Code 1 is valid only for registers 0 to 3. On any other register a code-1 write changes nothing, and a code-1 read returns 0.
- R10: A read of the register being written in the same cycle returns the merged value that the write will store.
- R11: Starting from any contents, the writes code 3 with 1, then code 1 with 2, then code 0 with 3 leave 0x0000000000000203.
- R12: A write changes only the addressed register, and a cycle with wr_en low changes none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Register written |
| wr_sel | input | 3 | View code of the write |
| wr_data | input | 64 | Write data, right-aligned to the view |
| rd_idx | input | 4 | Register read |
| rd_sel | input | 3 | View code of the read |
| rd_data | output | 64 | Selected view, zero-padded |

## Verification
The read path has no register, so rd_data is due in the same cycle that rd_idx and rd_sel are applied. That includes the forwarded value during a write to the same register. A write becomes visible in storage only after the rising edge that accepts it. The bench changes every input on the falling edge and samples rd_data 2 ns later, well before the next rising edge. Forwarding checks are therefore sampled while the write is still pending, and storage checks are made one falling edge after the write.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam logic [2:0] SEL_LO8 = 3'd0;
   localparam logic [2:0] SEL_HI8 = 3'd1;
   localparam logic [2:0] SEL_W16 = 3'd2;
   localparam logic [2:0] SEL_W32 = 3'd3;
   localparam logic [2:0] SEL_W64 = 3'd4;
endpackage

// File: rtl/regwin_merge.sv
module regwin_merge
   import regwin_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int IDX_W    = 4,
   parameter int HI8_REGS = 4
) (
   input  logic [DATA_W-1:0] old_val,
   input  logic [IDX_W-1:0]  idx,
   input  logic [2:0]        sel,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] new_val,
   output logic              legal
);
   localparam logic [IDX_W:0] HI8_LIM = HI8_REGS[IDX_W:0];

   always_comb begin
      legal   = 1'b1;
      new_val = old_val;
      case (sel)
         SEL_LO8: new_val[7:0] = data[7:0];
         SEL_HI8: begin
            if ({1'b0, idx} < HI8_LIM) new_val[15:8] = data[7:0];
            else                       legal = 1'b0;
         end
         SEL_W16: new_val[15:0] = data[15:0];
         SEL_W32: new_val = {{(DATA_W-32){1'b0}}, data[31:0]};
         SEL_W64: new_val = data;
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/regwin_extract.sv
module regwin_extract
   import regwin_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int IDX_W    = 4,
   parameter int HI8_REGS = 4
) (
   input  logic [DATA_W-1:0] word,
   input  logic [IDX_W-1:0]  idx,
   input  logic [2:0]        sel,
   output logic [DATA_W-1:0] win
);
   localparam logic [IDX_W:0] HI8_LIM = HI8_REGS[IDX_W:0];

   always_comb begin
      win = '0;
      case (sel)
         SEL_LO8: win[7:0]  = word[7:0];
         SEL_HI8: if ({1'b0, idx} < HI8_LIM) win[7:0] = word[15:8];
         SEL_W16: win[15:0] = word[15:0];
         SEL_W32: win[31:0] = word[31:0];
         SEL_W64: win       = word;
         default: win       = '0;
      endcase
   end
endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 64,
   parameter int IDX_W    = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 widx,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              q <= '0;
         else if (we && (widx == IDX_W'(g)))      q <= wdata;
      end
      assign regs_o[g] = q;
   end
endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 64,
   parameter int HI8_REGS = 4,
   parameter bit FWD_EN   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [2:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 32) begin : g_chk_w
      $error("regwin_file: DATA_W must be at least 32");
   end
   if (NUM_REGS < 2 || NUM_REGS != (1 << IDX_W)) begin : g_chk_n
      $error("regwin_file: NUM_REGS must be a power of two, at least 2");
   end
   if (HI8_REGS < 0 || HI8_REGS > NUM_REGS) begin : g_chk_h
      $error("regwin_file: HI8_REGS out of range");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
   logic [DATA_W-1:0]               merged;
   logic                            wr_legal;
   logic                            commit;
   logic [DATA_W-1:0]               rd_src;

   regwin_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HI8_REGS(HI8_REGS)) merge_i (
      .old_val (regs_q[wr_idx]),
      .idx     (wr_idx),
      .sel     (wr_sel),
      .data    (wr_data),
      .new_val (merged),
      .legal   (wr_legal)
   );

   assign commit = wr_en & wr_legal;

   regwin_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (commit),
      .widx   (wr_idx),
      .wdata  (merged),
      .regs_o (regs_q)
   );

   if (FWD_EN) begin : g_fwd
      always_comb begin
         if (commit && (wr_idx == rd_idx)) rd_src = merged;
         else                              rd_src = regs_q[rd_idx];
      end
   end else begin : g_nofwd
      assign rd_src = regs_q[rd_idx];
   end

   regwin_extract #(.DATA_W(DATA_W), .IDX_W(IDX_W), .HI8_REGS(HI8_REGS)) extract_i (
      .word (rd_src),
      .idx  (rd_idx),
      .sel  (rd_sel),
      .win  (rd_data)
   );
endmodule

// File: rtl/regwin_file_chk.sv
module regwin_file_chk
   import regwin_pkg::*;
#(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 64,
   parameter int HI8_REGS = 4,
   parameter bit FWD_EN   = 1'b1,
   parameter int IDX_W    = 4
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            wr_en,
   input logic [IDX_W-1:0]                wr_idx,
   input logic [2:0]                      wr_sel,
   input logic [DATA_W-1:0]               wr_data,
   input logic [IDX_W-1:0]                rd_idx,
   input logic [2:0]                      rd_sel,
   input logic [DATA_W-1:0]               rd_data,
   input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
   AST_LO8_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_LO8) |-> (rd_data[DATA_W-1:8] == '0)); // R2
   AST_W32_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_W32) |-> (rd_data[DATA_W-1:32] == '0)); // R2
   AST_W32_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W32) |=> (regs_q[$past(wr_idx)][DATA_W-1:32] == '0)); // R3
   AST_LO8_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_LO8) |=>
      (regs_q[$past(wr_idx)][DATA_W-1:8] == $past(regs_q[wr_idx][DATA_W-1:8]))); // R4
   AST_HI8_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_HI8) |=>
      ((regs_q[$past(wr_idx)][DATA_W-1:16] == $past(regs_q[wr_idx][DATA_W-1:16])) &&
       (regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0])))); // R5
   AST_W16_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W16) |=>
      (regs_q[$past(wr_idx)][DATA_W-1:16] == $past(regs_q[wr_idx][DATA_W-1:16]))); // R6
   AST_W64_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_W64) |=> (regs_q[$past(wr_idx)] == $past(wr_data))); // R7
   AST_BAD_SEL_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel > SEL_W64) |=> (regs_q == $past(regs_q))); // R8
   AST_BAD_SEL_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel > SEL_W64) |-> (rd_data == '0)); // R8
   AST_HI8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_HI8 && {1'b0, rd_idx} >= (IDX_W+1)'(HI8_REGS)) |-> (rd_data == '0)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en) |=> (regs_q == $past(regs_q))); // R12

   if (FWD_EN) begin : g_fwd_chk
      AST_FWD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == SEL_W64 && rd_sel == SEL_W64 && rd_idx == wr_idx)
         |-> (rd_data == wr_data)); // R10
   end
endmodule

bind regwin_file regwin_file_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .HI8_REGS (HI8_REGS),
   .FWD_EN   (FWD_EN),
   .IDX_W    (IDX_W)
) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_idx  (wr_idx),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .rd_idx  (rd_idx),
   .rd_sel  (rd_sel),
   .rd_data (rd_data),
   .regs_q  (regs_q)
);

// File: tb/regwin_file_tb_top.sv
module regwin_file_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [2:0]  wr_sel = '0;
   logic [63:0] wr_data = '0;
   logic [3:0]  rd_idx = '0;
   logic [2:0]  rd_sel = '0;
   logic [63:0] rd_data;

   int n_checks = 0;
   int n_errors = 0;

   always #10 clk = ~clk;

   regwin_file dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_sel  (rd_sel),
      .rd_data (rd_data)
   );

   task automatic check(input string req, input logic [63:0] exp);
      n_checks++;
      if (rd_data !== exp) begin
         n_errors++;
         $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
      end
   endtask

   task automatic rd(input logic [3:0] idx, input logic [2:0] sel,
                     input logic [63:0] exp, input string req);
      rd_idx = idx;
      rd_sel = sel;
      #2;
      check(req, exp);
   endtask

   task automatic wr(input logic [3:0] idx, input logic [2:0] sel, input logic [63:0] data);
      @(negedge clk);
      wr_idx = idx; wr_sel = sel; wr_data = data; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      for (int i = 0; i < 16; i++) rd(4'(i), 3'd4, 64'h0, "R1");
   endtask

   task automatic t_views;
      wr(4'd2, 3'd4, 64'h1122334455667788);
      rd(4'd2, 3'd4, 64'h1122334455667788, "R7");
      rd(4'd2, 3'd0, 64'h88, "R2");
      rd(4'd2, 3'd1, 64'h77, "R2");
      rd(4'd2, 3'd2, 64'h7788, "R2");
      rd(4'd2, 3'd3, 64'h55667788, "R2");
   endtask

   task automatic t_w32;
      wr(4'd2, 3'd3, 64'hFFFFFFFF_CAFEBABE);
      rd(4'd2, 3'd4, 64'h00000000_CAFEBABE, "R3");
   endtask

   task automatic t_lo8;
      wr(4'd5, 3'd4, 64'hFFFFFFFF_FFFFFFFF);
      wr(4'd5, 3'd0, 64'hAAAAAAAA_AAAAAA12);
      rd(4'd5, 3'd4, 64'hFFFFFFFF_FFFFFF12, "R4");
   endtask

   task automatic t_hi8_w16;
      wr(4'd1, 3'd4, 64'h01234567_89ABCDEF);
      wr(4'd1, 3'd1, 64'hFFFFFFFF_FFFFFF55);
      rd(4'd1, 3'd4, 64'h01234567_89AB55EF, "R5");
      wr(4'd1, 3'd2, 64'h11111111_1111BEEF);
      rd(4'd1, 3'd4, 64'h01234567_89ABBEEF, "R6");
   endtask

   task automatic t_bad_sel;
      wr(4'd1, 3'd5, 64'hFFFFFFFF_FFFFFFFF);
      wr(4'd1, 3'd7, 64'h0);
      rd(4'd1, 3'd4, 64'h01234567_89ABBEEF, "R8");
      rd(4'd1, 3'd6, 64'h0, "R8");
   endtask

   task automatic t_hi8_range;
      wr(4'd7, 3'd4, 64'h1234);
      wr(4'd7, 3'd1, 64'h99);
      rd(4'd7, 3'd4, 64'h1234, "R9");
      rd(4'd7, 3'd1, 64'h0, "R9");
      wr(4'd3, 3'd4, 64'hABCD);
      rd(4'd3, 3'd1, 64'hAB, "R9");
   endtask

   task automatic t_forward;
      @(negedge clk);
      wr_idx = 4'd3; wr_sel = 3'd3; wr_data = 64'h42; wr_en = 1'b1;
      rd(4'd3, 3'd4, 64'h42, "R10");
      rd(4'd7, 3'd4, 64'h1234, "R10");
      @(negedge clk);
      wr_idx = 4'd3; wr_sel = 3'd1; wr_data = 64'h7E;
      rd(4'd3, 3'd4, 64'h7E42, "R10");
      @(negedge clk);
      wr_en = 1'b0;
      rd(4'd3, 3'd4, 64'h7E42, "R10");
   endtask

   task automatic t_sequence;
      wr(4'd0, 3'd4, 64'hFFFFFFFF_FFFFFFFF);
      wr(4'd0, 3'd3, 64'h1);
      wr(4'd0, 3'd1, 64'h2);
      wr(4'd0, 3'd0, 64'h3);
      rd(4'd0, 3'd4, 64'h203, "R11");
   endtask

   task automatic t_isolation;
      @(negedge clk);
      wr_idx = 4'd7; wr_sel = 3'd4; wr_data = 64'hDEAD_BEEF; wr_en = 1'b0;
      @(negedge clk);
      rd(4'd7, 3'd4, 64'h1234, "R12");
      rd(4'd2, 3'd4, 64'h00000000_CAFEBABE, "R12");
      rd(4'd5, 3'd4, 64'hFFFFFFFF_FFFFFF12, "R12");
      rd(4'd9, 3'd4, 64'h0, "R12");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_views();
      t_w32();
      t_lo8();
      t_hi8_w16();
      t_bad_sel();
      t_hi8_range();
      t_forward();
      t_sequence();
      t_isolation();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule